// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a synchronous static RAM whose command, address, write-data and byte-lane inputs are all taken on the rising clock edge, while read data is not registered on the way out: the addressed word flows from the storage to the data outputs in the cycle that follows the edge that accepted the read. A write command is accepted together with its address and lane enables, and its data follows one clock later. This lets a bus master issue reads and writes in any order, one per cycle, without inserting idle cycles when the bus direction changes.

An advance input keeps the current access going with a 2-bit burst counter. The counter walks the four words of an aligned group either in linear order or in interleaved order. A static, unregistered mode pin picks the order. A chip select with one-cycle deselect and an asynchronous output enable control when the block drives its data output. The tri-state bus is modelled as a data word plus a separate drive-enable output. The word width, the lane count and the depth are parameters. The default is a 36-bit word in four 9-bit lanes over 64 words.

Top module: `zbt_ft_sram`

## Requirements
- R1: After reset no access is active and `dout_en` is low until a read command is accepted.
- R2: A read accepted on edge k (`adv_i`=0, `cs_n_i`=0, `we_n_i`=1) puts the addressed word on `dout_o` during the cycle after edge k, with `dout_en` high when `oe_n_i` is low.
- R3: A write accepted on edge k (`we_n_i`=0) takes its address and lane enables on edge k and its data from `din_i` on edge k+1, when the word is updated.
- R4: Lane i (bits 9i+8 down to 9i) is written only when `bw_n_i[i]` is low at the edge that accepts that beat; lanes with `bw_n_i[i]` high keep their old contents.
- R5: Reads and writes can alternate every cycle. A read of an address accepted on the edge right after that address's write command returns the newly written data, and `dout_en` stays low in each write-data cycle.
- R6: With `adv_i`=1 and an access active, the burst count steps by one (modulo 4) and the access keeps its direction, base address and a fresh set of lane enables sampled on that edge.
- R7: With `burst_il_i`=0 (linear), the two low address bits of a beat are (start + count) mod 4, and the upper address bits stay those of the start address.
- R8: With `burst_il_i`=1 (interleaved), the two low address bits of a beat are start XOR count. The pin is not registered.
- R9: `adv_i`=0 with `cs_n_i`=1 ends any access from the next cycle (`dout_en` low). `adv_i`=1 while no access is active leaves the block idle.
- R10: `oe_n_i` high forces `dout_en` low at once, without waiting for a clock edge, and dropping it again restores the read data.
- R11: While `adv_i`=1, `cs_n_i`, `we_n_i` and `addr_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_i | input | 1 | Chip select, active low, sampled when `adv_i` is 0 |
| we_n_i | input | 1 | Low selects a write, high a read, for a new access |
| adv_i | input | 1 | High continues the current access with the next burst beat |
| bw_n_i | input | LANES (4) | Per-lane write enables, active low, sampled on every edge |
| addr_i | input | ADDR_W (6) | Word address of a new access |
| din_i | input | DATA_W (36) | Write data, taken one edge after its write command |
| burst_il_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dout_o | output | DATA_W (36) | Read data flowing from the storage |
| dout_en | output | 1 | High when the block would drive the data bus |

## Verification
The hardest case to reach is the edge where a write's data is committed while a new read of the same word is accepted. The read must see the committed data even though the two share that edge, and the bus must swap direction with no gap. The bench reaches this case by running each address as a write command directly followed by a read command, so the write data and the read command share an edge. It also runs every start offset of a write burst followed by a read burst in both orders, with bursts that run past four beats and noise on the ignored pins.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              adv,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              op_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [1:0]        cnt_q,
  output logic [LANES-1:0]  lanes_q
);

  acc_e       op_d;
  logic [1:0] cnt_d;
  logic       load_en;

  // next-state
  always_comb begin
    op_d    = op_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    if (adv) begin
      if (op_q != ACC_IDLE) cnt_d = cnt_q + 2'd1;
    end else if (!cs_n) begin
      load_en = 1'b1;
      op_d    = we_n ? ACC_READ : ACC_WRITE;
      cnt_d   = 2'd0;
    end else begin
      op_d  = ACC_IDLE;
      cnt_d = 2'd0;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= ACC_IDLE;
      cnt_q <= 2'd0;
    end else begin
      op_q  <= op_d;
      cnt_q <= cnt_d;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (load_en) base_q <= addr;
    lanes_q <= ~bw_n;
  end

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && op_q != ACC_IDLE) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R9
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && cs_n) |=> (op_q == ACC_IDLE));

  // R11
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (op_q == $past(op_q)));

endmodule

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        cnt,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr
);

  logic [1:0] low;

  always_comb begin
    if (interleave) low = base[1:0] ^ cnt;
    else            low = base[1:0] + cnt;
  end

  generate
    if (ADDR_W > 2) begin : g_wide
      assign addr = {base[ADDR_W-1:2], low};
    end else begin : g_narrow
      assign addr = low[ADDR_W-1:0];
    end
  endgenerate

  // R7
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd0) |-> (addr == base));

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LW    = DATA_W / LANES;
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] lane_mem [DEPTH];
      logic          lane_we;

      assign lane_we = wr_en && wr_lanes[g];

      always_ff @(posedge clk) begin
        if (lane_we) lane_mem[wr_addr] <= wr_data[g*LW +: LW];
      end

      assign rd_data[g*LW +: LW] = lane_mem[rd_addr];
    end
  endgenerate

endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic              adv_i,
  input  logic [LANES-1:0]  bw_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              burst_il_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  acc_e              op_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [LANES-1:0]  lanes_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              commit_en;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cs_n    (cs_n_i),
    .we_n    (we_n_i),
    .adv     (adv_i),
    .bw_n    (bw_n_i),
    .addr    (addr_i),
    .op_q    (op_q),
    .base_q  (base_q),
    .cnt_q   (cnt_q),
    .lanes_q (lanes_q)
  );

  zbt_burst_addr #(.ADDR_W(ADDR_W)) i_baddr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .base       (base_q),
    .cnt        (cnt_q),
    .interleave (burst_il_i),
    .addr       (cur_addr)
  );

  // the registered write command is the pending write; its data lands now
  assign commit_en = (op_q == ACC_WRITE);

  zbt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_array (
    .clk      (clk),
    .wr_en    (commit_en),
    .wr_addr  (cur_addr),
    .wr_lanes (lanes_q),
    .wr_data  (din_i),
    .rd_addr  (cur_addr),
    .rd_data  (dout_o)
  );

  assign dout_en = !oe_n_i && (op_q == ACC_READ);

  // R5
  no_drive_on_wdata_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    commit_en |-> !dout_en);

  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_i && op_q != ACC_IDLE) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_int_n) |-> !dout_en);

endmodule

// File: tb/test_zbt_ft_sram.sv
module test_zbt_ft_sram;

  localparam int PER = 10;
  localparam int AW  = 6;
  localparam int DW  = 36;
  localparam int NL  = 4;
  localparam int LW  = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, we_n, adv, burst_il, oe_n;
  logic [NL-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [DW-1:0] ref_mem [64];
  int            m_op = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = 2'd0;
  logic [NL-1:0] m_lanes = '0;

  always #(PER/2) clk = ~clk;

  zbt_ft_sram i_zbt_ft_sram (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n),
    .we_n_i     (we_n),
    .adv_i      (adv),
    .bw_n_i     (bw_n),
    .addr_i     (addr),
    .din_i      (din),
    .burst_il_i (burst_il),
    .oe_n_i     (oe_n),
    .dout_o     (dout),
    .dout_en    (dout_en)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [DW-1:0] v;
    v = DW'(a) * 36'h9E3779B1 + DW'(salt) * 36'h0_0F1E_2D3B;
    return v ^ {DW{salt[0]}};
  endfunction

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = burst_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic v, input logic [NL-1:0] bw,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    logic exp_en;
    @(negedge clk);
    cs_n = c; we_n = w; adv = v; bw_n = bw; addr = a; din = d;
    @(posedge clk);
    if (m_op == 2) begin
      for (int i = 0; i < NL; i++)
        if (m_lanes[i]) ref_mem[m_addr()][i*LW +: LW] = d[i*LW +: LW];
    end
    if (v) begin
      if (m_op != 0) m_cnt = m_cnt + 2'd1;
    end else if (!c) begin
      m_op = w ? 1 : 2; m_base = a; m_cnt = 2'd0;
    end else begin
      m_op = 0; m_cnt = 2'd0;
    end
    m_lanes = ~bw;
    #(PER/4);
    exp_en = !oe_n && (m_op == 1);
    chk(dout_en == exp_en, req, DW'(dout_en), DW'(exp_en));
    if (exp_en) chk(dout == ref_mem[m_addr()], req, dout, ref_mem[m_addr()]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 36'd0, 36'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; adv = 1'b0; bw_n = '1;
    addr = '0; din = '0; burst_il = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #(PER/4);
    // R1: idle after reset
    chk(dout_en == 1'b0, "R1", DW'(dout_en), 36'd0);

    // R3: fill every word, data one cycle after its command
    for (int a = 0; a < 64; a++) step(1'b0, 1'b0, 1'b0, 4'h0, AW'(a), pat(a - 1, 1), "R3");
    step(1'b1, 1'b1, 1'b0, 4'hF, '0, pat(63, 1), "R3");

    // R2: flow-through read sweep
    for (int a = 0; a < 64; a++) step(1'b0, 1'b1, 1'b0, 4'hF, AW'(a), '0, "R2");

    // R5: write then read of the same word on consecutive edges
    for (int a = 0; a < 64; a++) begin
      step(1'b0, 1'b0, 1'b0, 4'h0, AW'(a), pat(a, 9), "R5");
      step(1'b0, 1'b1, 1'b0, 4'hF, AW'(a), pat(a, 2), "R5");
    end

    // R4: every lane-enable pattern
    for (int p = 0; p < 16; p++) begin
      step(1'b0, 1'b0, 1'b0, 4'(p), 6'd5, '0, "R4");
      step(1'b0, 1'b1, 1'b0, 4'hF, 6'd5, pat(p, 3), "R4");
    end

    // R6/R7/R8/R11: bursts from each start offset in both orders
    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b1, 1'b1, 1'b0, 4'hF, '0, '0, "R9");
        burst_il = il[0];
        step(1'b0, 1'b0, 1'b0, 4'h0, AW'(16 + 4 * s + s), '0, il ? "R8" : "R7");
        for (int b = 1; b < 6; b++)
          step(1'b1, 1'b1, 1'b1, (b == 3) ? 4'hA : 4'h0, 6'd63, pat(b, 10 + s + il * 4), "R11");
        step(1'b0, 1'b1, 1'b0, 4'hF, AW'(16 + 4 * s + s), pat(6, 10 + s + il * 4), il ? "R8" : "R7");
        for (int b = 1; b < 6; b++)
          step(1'b0, 1'b0, 1'b1, 4'h0, 6'd1, pat(b, 40), "R6");
      end
    end
    burst_il = 1'b0;

    // R9: deselect, then advance while idle
    step(1'b0, 1'b1, 1'b0, 4'hF, 6'd7, '0, "R2");
    step(1'b1, 1'b1, 1'b0, 4'hF, 6'd7, '0, "R9");
    step(1'b0, 1'b1, 1'b1, 4'hF, 6'd8, '0, "R9");
    step(1'b0, 1'b1, 1'b1, 4'hF, 6'd8, '0, "R9");

    // R10: asynchronous output enable
    step(1'b0, 1'b1, 1'b0, 4'hF, 6'd7, '0, "R2");
    oe_n = 1'b1;
    #1;
    chk(dout_en == 1'b0, "R10", DW'(dout_en), 36'd0);
    oe_n = 1'b0;
    #1;
    chk(dout_en == 1'b1, "R10", DW'(dout_en), 36'd1);
    chk(dout == ref_mem[7], "R10", dout, ref_mem[7]);

    step(1'b1, 1'b1, 1'b0, 4'hF, '0, '0, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule